// File: doc/BRIEF.md
# Two-Bank Interleaved Access Port

This block lets two requesters reach a word-addressed store in the same clock without any multi-ported storage cell. The store is split into two single-ported banks. The word-address bit just above the byte offset picks the bank, so consecutive words alternate between the banks and there is still only one copy of each word. An input crossbar steers each accepted request to its bank. An output crossbar routes each bank's read data back to the requester that issued the read.

Each requester has a ready/valid request channel that carries a write flag, a byte address, write data and a byte-enable mask. It also has a response channel that pulses once per accepted read. When both requesters target different banks, both are accepted in the same cycle. When both target the same bank, only one is accepted. The other sees ready low and must hold its request. Port 0 wins by default. A priority flag hands the next conflict to port 1 after port 1 has lost one.

Top module: `dual_bank_port`

## Requirements
- R1: Bank selection uses byte-address bit 2: a clear bit is bank 0 (even words) and a set bit is bank 1 (odd words). Bits 10:3 give the word index inside a bank. Bits 1:0 and bits above 10 play no part in the access, so address 0x800 aliases address 0x000.
- R2: A lone valid request is always accepted. Two valid requests to different banks are both accepted in the same cycle.
- R3: An accepted read raises the response valid of the same port exactly one cycle later, carrying the word stored at that address.
- R4: When two reads are accepted together, each port receives the data of its own address. This holds when port 0 reads bank 1 and port 1 reads bank 0.
- R5: Two valid requests to the same bank give exactly one ready. With the priority flag clear, port 0 is accepted and port 1 sees ready low.
- R6: After port 1 loses a conflict, the next conflict is granted to port 1, even when idle cycles come in between. The flag clears once port 1 is accepted, so the conflict after that goes to port 0.
- R7: On a write, byte lane k (data bits 8k+7:8k) is updated only when byte-enable bit k is set. Other lanes keep their old value.
- R8: A write, or a cycle with no accepted read, gives no response valid on that port in the next cycle.
- R9: After reset both readies are high, both response valids are low, and the priority flag is clear.
- R10: A request that is held back by a conflict does not touch the banks. A write that is refused and then withdrawn leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req0_valid | input | 1 | Port 0 request valid |
| req0_ready | output | 1 | Port 0 request accepted this cycle when valid |
| req0_write | input | 1 | Port 0 write (1) or read (0) |
| req0_addr | input | ADDR_W (16) | Port 0 byte address |
| req0_wdata | input | DATA_W (32) | Port 0 write data |
| req0_byte_en | input | DATA_W/8 (4) | Port 0 write byte mask |
| rsp0_valid | output | 1 | Port 0 read data valid |
| rsp0_rdata | output | DATA_W (32) | Port 0 read data |
| req1_valid | input | 1 | Port 1 request valid |
| req1_ready | output | 1 | Port 1 request accepted this cycle when valid |
| req1_write | input | 1 | Port 1 write (1) or read (0) |
| req1_addr | input | ADDR_W (16) | Port 1 byte address |
| req1_wdata | input | DATA_W (32) | Port 1 write data |
| req1_byte_en | input | DATA_W/8 (4) | Port 1 write byte mask |
| rsp1_valid | output | 1 | Port 1 read data valid |
| rsp1_rdata | output | DATA_W (32) | Port 1 read data |

## Verification
Single-port accesses to neighbouring words, to the top word of a bank and to an aliased address show that the bank bit and the index bits are taken from the right positions. Paired accesses to opposite banks, issued in the swapped arrangement, would expose an output crossbar that returns data by bank instead of by origin. Back-to-back same-bank pairs, including a refused write that is later withdrawn, separate fixed priority from the alternating flag. They also show whether a held-back request leaks into a bank. Partial byte masks on an already written word show lane-accurate writes.

// File: rtl/dbp_pkg.sv
package dbp_pkg;
  // Number of requesters and banks; the structure is two-by-two.
  localparam int NPORT = 2;
  localparam int NBANK = 2;

  typedef enum logic {
    SRC_P0 = 1'b0,
    SRC_P1 = 1'b1
  } src_e;
endpackage

// File: rtl/dbp_rst_sync.sv
module dbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dbp_arbiter.sv
module dbp_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic valid [2],
  input  logic bsel  [2],
  output logic ready [2],
  output logic grant [2]
);
  logic conflict;
  logic p1_first_q;
  logic p1_first_d;
  logic p1_first_en;

  // Same-bank collision between the two requesters.
  assign conflict = valid[0] & valid[1] & (bsel[0] == bsel[1]);

  always_comb begin
    ready[0] = ~(conflict &  p1_first_q);
    ready[1] = ~(conflict & ~p1_first_q);
    grant[0] = valid[0] & ready[0];
    grant[1] = valid[1] & ready[1];
  end

  // Raise the flag when port 1 loses; drop it once port 1 gets through.
  always_comb begin
    p1_first_d  = p1_first_q;
    p1_first_en = 1'b0;
    if (conflict && !p1_first_q) begin
      p1_first_d  = 1'b1;
      p1_first_en = 1'b1;
    end else if (grant[1] && p1_first_q) begin
      p1_first_d  = 1'b0;
      p1_first_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           p1_first_q <= 1'b0;
    else if (p1_first_en) p1_first_q <= p1_first_d;
  end
endmodule

// File: rtl/dbp_in_xbar.sv
module dbp_in_xbar #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              grant  [2],
  input  logic              bsel   [2],
  input  logic              write  [2],
  input  logic [IDX_W-1:0]  idx    [2],
  input  logic [DATA_W-1:0] wdata  [2],
  input  logic [BE_W-1:0]   be     [2],
  output logic              b_en   [2],
  output logic              b_we   [2],
  output logic              b_src  [2],
  output logic [IDX_W-1:0]  b_idx  [2],
  output logic [DATA_W-1:0] b_wdata[2],
  output logic [BE_W-1:0]   b_be   [2]
);
  for (genvar b = 0; b < dbp_pkg::NBANK; b++) begin : g_bank
    localparam bit BID = (b == 1);
    logic hit0;
    logic hit1;

    assign hit0 = grant[0] & (bsel[0] == BID);
    assign hit1 = grant[1] & (bsel[1] == BID);

    // At most one hit per bank: the arbiter never grants a collision.
    always_comb begin
      b_en[b]    = hit0 | hit1;
      b_src[b]   = hit1;
      b_we[b]    = hit1 ? write[1] : write[0];
      b_idx[b]   = hit1 ? idx[1]   : idx[0];
      b_wdata[b] = hit1 ? wdata[1] : wdata[0];
      b_be[b]    = hit1 ? be[1]    : be[0];
    end
  end
endmodule

// File: rtl/dbp_bank.sv
module dbp_bank #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              wr_en;
  logic              rd_en;

  assign wr_en = en &  we;
  assign rd_en = en & ~we;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < BE_W; k++) begin
        if (be[k]) mem[idx][8*k +: 8] <= wdata[8*k +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata_q <= mem[idx];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dbp_out_xbar.sv
module dbp_out_xbar #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              b_rd   [2],
  input  logic              b_src  [2],
  input  logic [DATA_W-1:0] b_rdata[2],
  output logic              rsp_v  [2],
  output logic [DATA_W-1:0] rsp_d  [2]
);
  import dbp_pkg::*;

  logic pend_q [2];
  logic pend_d [2];
  src_e tag_q  [2];
  src_e tag_d  [2];
  logic tag_en [2];

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      pend_d[b] = b_rd[b];
      tag_en[b] = b_rd[b];
      tag_d[b]  = b_src[b] ? SRC_P1 : SRC_P0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NBANK; b++) begin
        pend_q[b] <= 1'b0;
        tag_q[b]  <= SRC_P0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        pend_q[b] <= pend_d[b];
        if (tag_en[b]) tag_q[b] <= tag_d[b];
      end
    end
  end

  // Route each bank's returning word by the tag of its issuing port.
  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rsp_v[p] = 1'b0;
      rsp_d[p] = '0;
      for (int b = 0; b < NBANK; b++) begin
        if (pend_q[b] && (tag_q[b] == src_e'(p[0]))) begin
          rsp_v[p] = 1'b1;
          rsp_d[p] = b_rdata[b];
        end
      end
    end
  end
endmodule

// File: rtl/dual_bank_port.sv
module dual_bank_port #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 32,
  parameter int BANK_WORDS = 256,
  parameter int BANK_BIT   = 2,
  localparam int BE_W      = DATA_W / 8,
  localparam int IDX_W     = $clog2(BANK_WORDS),
  localparam int IDX_LO    = BANK_BIT + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0_valid,
  output logic              req0_ready,
  input  logic              req0_write,
  input  logic [ADDR_W-1:0] req0_addr,
  input  logic [DATA_W-1:0] req0_wdata,
  input  logic [BE_W-1:0]   req0_byte_en,
  output logic              rsp0_valid,
  output logic [DATA_W-1:0] rsp0_rdata,
  input  logic              req1_valid,
  output logic              req1_ready,
  input  logic              req1_write,
  input  logic [ADDR_W-1:0] req1_addr,
  input  logic [DATA_W-1:0] req1_wdata,
  input  logic [BE_W-1:0]   req1_byte_en,
  output logic              rsp1_valid,
  output logic [DATA_W-1:0] rsp1_rdata
);
  logic              rst_n_sync;
  logic              valid  [2];
  logic              ready  [2];
  logic              grant  [2];
  logic              bsel   [2];
  logic              write  [2];
  logic [IDX_W-1:0]  idx    [2];
  logic [DATA_W-1:0] wdata  [2];
  logic [BE_W-1:0]   be     [2];
  logic              b_en   [2];
  logic              b_we   [2];
  logic              b_src  [2];
  logic              b_rd   [2];
  logic [IDX_W-1:0]  b_idx  [2];
  logic [DATA_W-1:0] b_wdata[2];
  logic [BE_W-1:0]   b_be   [2];
  logic [DATA_W-1:0] b_rdata[2];
  logic              rsp_v  [2];
  logic [DATA_W-1:0] rsp_d  [2];
  logic              unused_addr_bits;

  dbp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  // Address decode per requester.
  always_comb begin
    valid[0] = req0_valid;
    valid[1] = req1_valid;
    write[0] = req0_write;
    write[1] = req1_write;
    wdata[0] = req0_wdata;
    wdata[1] = req1_wdata;
    be[0]    = req0_byte_en;
    be[1]    = req1_byte_en;
    bsel[0]  = req0_addr[BANK_BIT];
    bsel[1]  = req1_addr[BANK_BIT];
    idx[0]   = req0_addr[IDX_LO +: IDX_W];
    idx[1]   = req1_addr[IDX_LO +: IDX_W];
  end

  assign unused_addr_bits = ^{req0_addr[BANK_BIT-1:0], req1_addr[BANK_BIT-1:0],
                              req0_addr[ADDR_W-1:IDX_LO+IDX_W],
                              req1_addr[ADDR_W-1:IDX_LO+IDX_W]};

  dbp_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .valid (valid),
    .bsel  (bsel),
    .ready (ready),
    .grant (grant)
  );

  dbp_in_xbar #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) u_ixb (
    .grant   (grant),
    .bsel    (bsel),
    .write   (write),
    .idx     (idx),
    .wdata   (wdata),
    .be      (be),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_src   (b_src),
    .b_idx   (b_idx),
    .b_wdata (b_wdata),
    .b_be    (b_be)
  );

  for (genvar b = 0; b < dbp_pkg::NBANK; b++) begin : g_bank
    assign b_rd[b] = b_en[b] & ~b_we[b];

    dbp_bank #(
      .DEPTH  (BANK_WORDS),
      .DATA_W (DATA_W),
      .BE_W   (BE_W),
      .IDX_W  (IDX_W)
    ) u_bank (
      .clk   (clk),
      .en    (b_en[b]),
      .we    (b_we[b]),
      .idx   (b_idx[b]),
      .wdata (b_wdata[b]),
      .be    (b_be[b]),
      .rdata (b_rdata[b])
    );
  end

  dbp_out_xbar #(
    .DATA_W (DATA_W)
  ) u_oxb (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .b_rd    (b_rd),
    .b_src   (b_src),
    .b_rdata (b_rdata),
    .rsp_v   (rsp_v),
    .rsp_d   (rsp_d)
  );

  assign req0_ready = ready[0];
  assign req1_ready = ready[1];
  assign rsp0_valid = rsp_v[0];
  assign rsp1_valid = rsp_v[1];
  assign rsp0_rdata = rsp_d[0];
  assign rsp1_rdata = rsp_d[1];
endmodule

// File: rtl/dbp_checker.sv
module dbp_checker #(
  parameter int ADDR_W   = 16,
  parameter int BANK_BIT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              v0,
  input logic              r0,
  input logic              w0,
  input logic [ADDR_W-1:0] a0,
  input logic              o0,
  input logic              v1,
  input logic              r1,
  input logic              w1,
  input logic [ADDR_W-1:0] a1,
  input logic              o1
);
  logic same_bank;
  logic collide;

  assign same_bank = (a0[BANK_BIT] == a1[BANK_BIT]);
  assign collide   = v0 & v1 & same_bank;

  // R2: opposite banks never stall either side
  a_r2_split_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && v1 && !same_bank) |-> (r0 && r1));

  // R2: a lone request is accepted
  a_r2_lone_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && !v1) |-> r0);

  // R5: a collision lets exactly one side through
  a_r5_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    collide |-> ($countones({r0, r1}) == 1));

  // R6: port 1 refused on a collision wins the next one
  a_r6_port1_next: assert property (@(posedge clk) disable iff (!rst_n)
    (collide && !r1) |=> (!collide || (r1 && !r0)));

  // R3: accepted reads answer one cycle later on the same port
  a_r3_rsp_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (v0 && r0 && !w0) |=> o0);
  a_r3_rsp_port1: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && r1 && !w1) |=> o1);

  // R8: no response without an accepted read
  a_r8_quiet_port0: assert property (@(posedge clk) disable iff (!rst_n)
    !(v0 && r0 && !w0) |=> !o0);
  a_r8_quiet_port1: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 && r1 && !w1) |=> !o1);
endmodule

bind dual_bank_port dbp_checker #(
  .ADDR_W   (ADDR_W),
  .BANK_BIT (BANK_BIT)
) u_chk (
  .clk   (clk),
  .rst_n (rst_n_sync),
  .v0    (req0_valid),
  .r0    (req0_ready),
  .w0    (req0_write),
  .a0    (req0_addr),
  .o0    (rsp0_valid),
  .v1    (req1_valid),
  .r1    (req1_ready),
  .w1    (req1_write),
  .a1    (req1_addr),
  .o1    (rsp1_valid)
);

// File: tb/dual_bank_port_tb_top.sv
module dual_bank_port_tb_top;
  logic        clk;
  logic        rst_n;
  logic        req0_valid, req0_ready, req0_write, rsp0_valid;
  logic [15:0] req0_addr;
  logic [31:0] req0_wdata, rsp0_rdata;
  logic [3:0]  req0_byte_en;
  logic        req1_valid, req1_ready, req1_write, rsp1_valid;
  logic [15:0] req1_addr;
  logic [31:0] req1_wdata, rsp1_rdata;
  logic [3:0]  req1_byte_en;

  int n_total = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam logic [31:0] VAL_A = 32'hA0A0_0001;
  localparam logic [31:0] VAL_B = 32'hB0B0_0002;
  localparam logic [31:0] VAL_C = 32'hC0C0_00FF;
  localparam logic [31:0] VAL_E = 32'hE0E0_0011;
  localparam logic [31:0] VAL_D0 = 32'h0D0D_1000;
  localparam logic [31:0] VAL_D1 = 32'h1D1D_2000;

  dual_bank_port dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req0_valid   (req0_valid),
    .req0_ready   (req0_ready),
    .req0_write   (req0_write),
    .req0_addr    (req0_addr),
    .req0_wdata   (req0_wdata),
    .req0_byte_en (req0_byte_en),
    .rsp0_valid   (rsp0_valid),
    .rsp0_rdata   (rsp0_rdata),
    .req1_valid   (req1_valid),
    .req1_ready   (req1_ready),
    .req1_write   (req1_write),
    .req1_addr    (req1_addr),
    .req1_wdata   (req1_wdata),
    .req1_byte_en (req1_byte_en),
    .rsp1_valid   (rsp1_valid),
    .rsp1_rdata   (rsp1_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_total++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drv0(bit v, bit w, logic [15:0] a, logic [31:0] d, logic [3:0] be);
    req0_valid = v; req0_write = w; req0_addr = a; req0_wdata = d; req0_byte_en = be;
  endtask

  task automatic drv1(bit v, bit w, logic [15:0] a, logic [31:0] d, logic [3:0] be);
    req1_valid = v; req1_write = w; req1_addr = a; req1_wdata = d; req1_byte_en = be;
  endtask

  task automatic idle();
    drv0(0, 0, '0, '0, '0);
    drv1(0, 0, '0, '0, '0);
  endtask

  task automatic wr(int p, logic [15:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    if (p == 0) drv0(1, 1, a, d, be); else drv1(1, 1, a, d, be);
    @(negedge clk);
    idle();
  endtask

  task automatic rd_check(int p, logic [15:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    if (p == 0) drv0(1, 0, a, '0, '0); else drv1(1, 0, a, '0, '0);
    @(negedge clk);
    idle();
    #1;
    if (p == 0) begin
      chk({req, " rsp0_valid"}, 32'(rsp0_valid), 32'd1);
      chk({req, " rsp0_rdata"}, rsp0_rdata, exp);
    end else begin
      chk({req, " rsp1_valid"}, 32'(rsp1_valid), 32'd1);
      chk({req, " rsp1_rdata"}, rsp1_rdata, exp);
    end
  endtask

  // R9: state right after reset
  task automatic t_reset();
    #1;
    chk("R9 req0_ready", 32'(req0_ready), 32'd1);
    chk("R9 req1_ready", 32'(req1_ready), 32'd1);
    chk("R9 rsp0_valid", 32'(rsp0_valid), 32'd0);
    chk("R9 rsp1_valid", 32'(rsp1_valid), 32'd0);
  endtask

  // R1: bank bit, index bits, ignored offset and upper bits
  task automatic t_bank_map();
    wr(0, 16'h0000, VAL_A, 4'hF);
    wr(0, 16'h0004, VAL_B, 4'hF);
    wr(0, 16'h07F8, VAL_C, 4'hF);
    wr(1, 16'h0008, VAL_E, 4'hF);
    rd_check(0, 16'h0000, VAL_A, "R1 even word");
    rd_check(1, 16'h0004, VAL_B, "R1 odd word");
    rd_check(0, 16'h07FB, VAL_C, "R1 top index, byte offset");
    rd_check(1, 16'h0800, VAL_A, "R1 alias upper bits");
    rd_check(0, 16'h0008, VAL_E, "R1 bank0 index1");
  endtask

  // R2, R3, R4, R8: both ports on opposite banks
  task automatic t_parallel();
    @(negedge clk);
    drv0(1, 1, 16'h0010, VAL_D0, 4'hF);
    drv1(1, 1, 16'h0014, VAL_D1, 4'hF);
    #1;
    chk("R2 split write ready0", 32'(req0_ready), 32'd1);
    chk("R2 split write ready1", 32'(req1_ready), 32'd1);
    @(negedge clk);
    drv0(1, 0, 16'h0014, '0, '0);
    drv1(1, 0, 16'h0010, '0, '0);
    #1;
    chk("R8 no rsp0 after write", 32'(rsp0_valid), 32'd0);
    chk("R8 no rsp1 after write", 32'(rsp1_valid), 32'd0);
    chk("R2 split read ready0", 32'(req0_ready), 32'd1);
    chk("R2 split read ready1", 32'(req1_ready), 32'd1);
    @(negedge clk);
    idle();
    #1;
    chk("R3 rsp0_valid", 32'(rsp0_valid), 32'd1);
    chk("R4 port0 gets bank1 word", rsp0_rdata, VAL_D1);
    chk("R3 rsp1_valid", 32'(rsp1_valid), 32'd1);
    chk("R4 port1 gets bank0 word", rsp1_rdata, VAL_D0);
    @(negedge clk);
    #1;
    chk("R8 idle rsp0", 32'(rsp0_valid), 32'd0);
    chk("R8 idle rsp1", 32'(rsp1_valid), 32'd0);
  endtask

  // R7: partial byte-lane writes
  task automatic t_byte_mask();
    wr(0, 16'h0020, 32'h1122_3344, 4'hF);
    wr(1, 16'h0020, 32'hAABB_CCDD, 4'b0101);
    rd_check(0, 16'h0020, 32'h11BB_33DD, "R7 mask 0101");
    wr(0, 16'h0020, 32'h5566_7788, 4'b1000);
    rd_check(1, 16'h0020, 32'h55BB_33DD, "R7 mask 1000");
  endtask

  // R5, R6, R10: same-bank collisions
  task automatic t_conflict();
    @(negedge clk);
    drv0(1, 0, 16'h0000, '0, '0);
    drv1(1, 0, 16'h0008, '0, '0);
    #1;
    chk("R5 port0 wins ready0", 32'(req0_ready), 32'd1);
    chk("R5 port1 held ready1", 32'(req1_ready), 32'd0);
    @(negedge clk);
    #1;
    chk("R3 rsp0 after win", rsp0_rdata, VAL_A);
    chk("R5 loser no rsp1", 32'(rsp1_valid), 32'd0);
    drv0(1, 0, 16'h0000, '0, '0);
    #1;
    chk("R6 port1 wins next ready1", 32'(req1_ready), 32'd1);
    chk("R6 port0 held ready0", 32'(req0_ready), 32'd0);
    @(negedge clk);
    drv1(0, 0, '0, '0, '0);
    #1;
    chk("R6 rsp1_valid", 32'(rsp1_valid), 32'd1);
    chk("R6 rsp1_rdata", rsp1_rdata, VAL_E);
    chk("R6 lone port0 ready", 32'(req0_ready), 32'd1);
    @(negedge clk);
    #1;
    chk("R3 retried rsp0", rsp0_rdata, VAL_A);
    // Flag clear again: port 0 must win; port 1 offers a write.
    drv0(1, 0, 16'h0000, '0, '0);
    drv1(1, 1, 16'h0008, 32'hDEAD_BEEF, 4'hF);
    #1;
    chk("R6 flag cleared ready0", 32'(req0_ready), 32'd1);
    chk("R10 write held ready1", 32'(req1_ready), 32'd0);
    @(negedge clk);
    idle();
    @(negedge clk);
    rd_check(0, 16'h0008, VAL_E, "R10 refused write left word");
    // Flag still set across idle cycles.
    @(negedge clk);
    drv0(1, 0, 16'h0000, '0, '0);
    drv1(1, 0, 16'h0008, '0, '0);
    #1;
    chk("R6 sticky flag ready1", 32'(req1_ready), 32'd1);
    chk("R6 sticky flag ready0", 32'(req0_ready), 32'd0);
    @(negedge clk);
    idle();
    #1;
    chk("R6 sticky rsp1", rsp1_rdata, VAL_E);
    chk("R6 sticky no rsp0", 32'(rsp0_valid), 32'd0);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_bank_map();
    t_parallel();
    t_byte_mask();
    t_conflict();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule